// File: doc/BRIEF.md
# Interrupt-Aware Instruction Cycle Sequencer

This block is the control state machine that walks a small processor through its instruction cycle. It has three phases. In the fetch phase it requests the word at the program counter from memory, loads that word into the instruction register and advances the counter. In the execute phase it hands the opcode to an external execute unit and waits for that unit to report completion. In the check phase, which lasts one cycle, it looks at the interrupt-pending line.

When an interrupt is pending and interrupts are enabled, the check phase suspends the running program. The program counter and the enable flag go into a context register, the enable flag is cleared and the counter is loaded with a fixed handler address. When the handler finishes, it executes a return, which the execute unit signals together with its done strobe. The return reloads the counter from the context register and re-enables interrupts, so the interrupted program resumes at the instruction it would have fetched next.

Memory is reached through a request/ready handshake. Decoding of operations, the ALU and the memory array sit outside this block.

Top module: `instr_cycle_seq`

## Requirements
- R1: Synchronous active-high reset sets the program counter to 0 and the enable flag to 1 and clears the context register. The sequencer then sits in fetch with `mem_req`=1, `mem_addr`=0, `exec_valid`=0 and `irq_ack`=0.
- R2: In fetch, `mem_req` is 1 and `mem_addr` equals the program counter. Both hold unchanged, and nothing else advances, for as long as `mem_ready` stays 0.
- R3: On the cycle the fetch is accepted (`mem_req` and `mem_ready` both 1), the program counter becomes its old value plus 1, modulo 2^AW. `exec_valid` is 1 from the next cycle.
- R4: The accepted fetch loads `mem_rdata` into `ir`. `opcode` always equals the upper OPW bits of `ir`.
- R5: `exec_valid` stays 1 until `exec_done` is seen. A done with `exec_jump`=1 (and `exec_rti`=0) loads the program counter with `exec_target`. A done without `exec_jump` leaves the counter at the incremented value. `exec_done`, `exec_jump` and `exec_target` have no effect outside the execute phase.
- R6: Every execute phase is followed by exactly one check cycle, in which `mem_req` and `exec_valid` are 0. With no interrupt taken, the next cycle is a fetch at the unchanged counter. `irq_pending` has no effect in any other phase.
- R7: In the check cycle, `irq_pending`=1 with the enable flag at 1 raises `irq_ack` for that single cycle. The counter and flag are saved to the context register, the counter becomes HANDLER_VEC and the flag is cleared, so the next fetch reads HANDLER_VEC.
- R8: While the enable flag is 0, `irq_pending` in the check cycle gives `irq_ack`=0 and the counter and flag are unchanged.
- R9: A done with `exec_rti`=1 takes priority over `exec_jump`. It loads the counter from the context register and sets the enable flag to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory read request, high throughout fetch |
| mem_addr | output | AW | Read address (program counter) |
| mem_ready | input | 1 | Memory has the word on `mem_rdata` |
| mem_rdata | input | DW | Fetched word |
| ir | output | DW | Instruction register |
| opcode | output | OPW | Upper bits of `ir` for the execute unit |
| exec_valid | output | 1 | Execute phase active |
| exec_done | input | 1 | Execute unit finished |
| exec_jump | input | 1 | With done: redirect the counter |
| exec_target | input | AW | Redirect address |
| exec_rti | input | 1 | With done: return from interrupt |
| irq_pending | input | 1 | Interrupt request level |
| irq_ack | output | 1 | One-cycle pulse when an interrupt is taken |
| pc | output | AW | Program counter |
| int_en | output | 1 | Interrupt enable flag |

## Verification
The properties assume that `mem_ready` and `exec_done` are only meaningful while the matching phase is active. They also assume that `exec_rti` comes only from a handler, so that the context register holds a valid return address. The stimulus drives every input at the falling edge. It raises `mem_ready` only while a request is open and issues a return only after an interrupt has been taken. It also deliberately pulses `exec_done` with a jump during a stalled fetch and holds `irq_pending` during execute, to show that these inputs are ignored outside their phases.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_CHECK = 2'd2
    } phase_t;

    function automatic phase_t phase_step(input phase_t cur, input logic ready,
                                          input logic done);
        phase_t nxt;
        nxt = cur;
        case (cur)
            PH_FETCH: if (ready) nxt = PH_EXEC;
            PH_EXEC:  if (done)  nxt = PH_CHECK;
            default:             nxt = PH_FETCH;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/isc_phase_fsm.sv
module isc_phase_fsm
    import isc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mem_ready,
    input  logic exec_done,
    output logic in_fetch,
    output logic in_exec,
    output logic in_check,
    output logic fetch_take,
    output logic exec_take
);
    phase_t phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_FETCH;
        else     phase_q <= phase_step(phase_q, mem_ready, exec_done);
    end

    always_comb begin
        in_fetch   = (phase_q == PH_FETCH);
        in_exec    = (phase_q == PH_EXEC);
        in_check   = (phase_q == PH_CHECK);
        fetch_take = in_fetch && mem_ready;
        exec_take  = in_exec && exec_done;
    end

    AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        in_exec && !exec_done |=> in_exec); // R5
    AST_CHECK_ONE: assert property (@(posedge clk) disable iff (rst)
        in_check |=> in_fetch); // R6

endmodule

// File: rtl/isc_ir_reg.sv
module isc_ir_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d)); // R4

endmodule

// File: rtl/isc_pc_unit.sv
module isc_pc_unit #(
    parameter int          AW          = 16,
    parameter logic [AW-1:0] HANDLER_VEC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_take,
    input  logic          exec_take,
    input  logic          in_check,
    input  logic          exec_jump,
    input  logic [AW-1:0] exec_target,
    input  logic          exec_rti,
    input  logic          irq_pending,
    output logic [AW-1:0] pc,
    output logic          int_en,
    output logic          irq_ack
);
    typedef struct packed {
        logic [AW-1:0] pc;
        logic          ie;
    } ctx_t;

    ctx_t ctx_q;

    assign irq_ack = in_check && irq_pending && int_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            int_en <= 1'b1;
            ctx_q  <= '0;
        end else if (fetch_take) begin
            pc <= pc + 1'b1;
        end else if (exec_take) begin
            if (exec_rti) begin
                pc     <= ctx_q.pc;
                int_en <= 1'b1;
            end else if (exec_jump) begin
                pc <= exec_target;
            end
        end else if (irq_ack) begin
            ctx_q  <= '{pc: pc, ie: int_en};
            pc     <= HANDLER_VEC;
            int_en <= 1'b0;
        end
    end

    AST_PC_INC: assert property (@(posedge clk) disable iff (rst)
        fetch_take |=> pc == $past(pc) + 1'b1); // R3
    AST_VECTOR: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> pc == HANDLER_VEC && !int_en); // R7
    AST_MASKED: assert property (@(posedge clk) disable iff (rst)
        in_check && !int_en |=> !int_en && pc == $past(pc)); // R8
    AST_RESTORE: assert property (@(posedge clk) disable iff (rst)
        exec_take && exec_rti |=> int_en); // R9

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq #(
    parameter int            AW          = 16,
    parameter int            DW          = 16,
    parameter int            OPW         = 4,
    parameter logic [AW-1:0] HANDLER_VEC = 16'h0100
) (
    input  logic           clk,
    input  logic           rst,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_ready,
    input  logic [DW-1:0]  mem_rdata,
    output logic [DW-1:0]  ir,
    output logic [OPW-1:0] opcode,
    output logic           exec_valid,
    input  logic           exec_done,
    input  logic           exec_jump,
    input  logic [AW-1:0]  exec_target,
    input  logic           exec_rti,
    input  logic           irq_pending,
    output logic           irq_ack,
    output logic [AW-1:0]  pc,
    output logic           int_en
);
    localparam int OP_LSB = DW - OPW;

    logic in_fetch, in_exec, in_check, fetch_take, exec_take;

    isc_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .mem_ready(mem_ready), .exec_done(exec_done),
        .in_fetch(in_fetch), .in_exec(in_exec), .in_check(in_check),
        .fetch_take(fetch_take), .exec_take(exec_take)
    );

    isc_ir_reg #(.DW(DW)) u_ir (
        .clk(clk), .rst(rst), .load(fetch_take), .d(mem_rdata), .q(ir)
    );

    isc_pc_unit #(.AW(AW), .HANDLER_VEC(HANDLER_VEC)) u_pc (
        .clk(clk), .rst(rst), .fetch_take(fetch_take), .exec_take(exec_take),
        .in_check(in_check), .exec_jump(exec_jump), .exec_target(exec_target),
        .exec_rti(exec_rti), .irq_pending(irq_pending),
        .pc(pc), .int_en(int_en), .irq_ack(irq_ack)
    );

    assign mem_req    = in_fetch;
    assign mem_addr   = pc;
    assign exec_valid = in_exec;
    assign opcode     = ir[DW-1:OP_LSB];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R2
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> !mem_req && !exec_valid); // R6

endmodule

// File: tb/instr_cycle_seq_test.sv
module instr_cycle_seq_test;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int OPW = 4;
    localparam logic [AW-1:0] VEC = 16'h0100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic exec_done = 1'b0, exec_jump = 1'b0, exec_rti = 1'b0, irq_pending = 1'b0;
    logic [AW-1:0] exec_target = '0;
    logic mem_req, exec_valid, irq_ack, int_en;
    logic [AW-1:0] mem_addr, pc;
    logic [DW-1:0] ir;
    logic [OPW-1:0] opcode;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] addr_q[$];

    always #2.5 clk = ~clk;

    instr_cycle_seq #(.AW(AW), .DW(DW), .OPW(OPW), .HANDLER_VEC(VEC)) uut (
        .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .ir(ir), .opcode(opcode),
        .exec_valid(exec_valid), .exec_done(exec_done), .exec_jump(exec_jump),
        .exec_target(exec_target), .exec_rti(exec_rti), .irq_pending(irq_pending),
        .irq_ack(irq_ack), .pc(pc), .int_en(int_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compare every accepted fetch address with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && mem_req && mem_ready) begin
                if (addr_q.size() == 0) check("R2 unexpected fetch", 32'(mem_addr), 32'hFFFF_FFFF);
                else check("R2 fetch address", 32'(mem_addr), 32'(addr_q.pop_front()));
            end
        end
    end

    task automatic do_fetch(input logic [AW-1:0] addr, input int waits,
                            input logic [DW-1:0] word, input logic glitch);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            mem_ready = 1'b0;
            exec_done = glitch; exec_jump = glitch; exec_target = 16'hBEEF;
            irq_pending = glitch;
            #1;
            check("R2 req held", {31'd0, mem_req}, 32'd1);
            check("R2 addr held", 32'(mem_addr), 32'(addr));
        end
        @(negedge clk);
        exec_done = 1'b0; exec_jump = 1'b0; irq_pending = 1'b0;
        addr_q.push_back(addr);
        mem_rdata = word; mem_ready = 1'b1;
        #1;
        @(negedge clk);
        mem_ready = 1'b0;
        #1;
        check("R4 ir", 32'(ir), 32'(word));
        check("R4 opcode", 32'(opcode), 32'(word[DW-1 -: OPW]));
        check("R3 pc inc", 32'(pc), 32'(addr + 1'b1));
        check("R3 exec_valid", {31'd0, exec_valid}, 32'd1);
    endtask

    task automatic do_exec(input int lat, input logic jump, input logic [AW-1:0] tgt,
                           input logic rti, input logic irq_during, input logic [AW-1:0] pc_exp);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            irq_pending = irq_during;
            #1;
            check("R5 exec held", {31'd0, exec_valid}, 32'd1);
            check("R6 irq ignored in exec", 32'(pc), 32'(pc_exp));
        end
        @(negedge clk);
        irq_pending = 1'b0;
        exec_done = 1'b1; exec_jump = jump; exec_target = tgt; exec_rti = rti;
        #1;
        @(negedge clk);
        exec_done = 1'b0; exec_jump = 1'b0; exec_rti = 1'b0;
    endtask

    task automatic do_check(input logic irq, input logic ack_exp,
                            input logic [AW-1:0] pc_exp, input logic ie_exp, input string req);
        irq_pending = irq;
        #1;
        check({req, " ack"}, {31'd0, irq_ack}, {31'd0, ack_exp});
        check("R6 quiet check", {30'd0, mem_req, exec_valid}, 32'd0);
        @(negedge clk);
        irq_pending = 1'b0;
        #1;
        check({req, " pc"}, 32'(pc), 32'(pc_exp));
        check({req, " ie"}, {31'd0, int_en}, {31'd0, ie_exp});
        check("R6 fetch next", {31'd0, mem_req}, 32'd1);
        check("R6 addr next", 32'(mem_addr), 32'(pc_exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 pc", 32'(pc), 32'd0);
        check("R1 ie", {31'd0, int_en}, 32'd1);
        check("R1 req", {31'd0, mem_req}, 32'd1);
        check("R1 exec_valid", {31'd0, exec_valid}, 32'd0);
        check("R1 ack", {31'd0, irq_ack}, 32'd0);

        // plain step
        do_fetch(16'h0000, 0, 16'hA123, 1'b0);
        do_exec(0, 1'b0, '0, 1'b0, 1'b0, 16'h0001);
        do_check(1'b0, 1'b0, 16'h0001, 1'b1, "R6 no irq");
        // stalled fetch with ignored done/jump/irq, then jump
        do_fetch(16'h0001, 3, 16'h5E01, 1'b1);
        do_exec(2, 1'b1, 16'h0020, 1'b0, 1'b0, 16'h0002);
        do_check(1'b0, 1'b0, 16'h0020, 1'b1, "R5 jump");
        // interrupt taken
        do_fetch(16'h0020, 1, 16'h7777, 1'b0);
        do_exec(1, 1'b0, '0, 1'b0, 1'b0, 16'h0021);
        do_check(1'b1, 1'b1, VEC, 1'b0, "R7 take");
        // masked interrupt inside handler
        do_fetch(VEC, 0, 16'hC001, 1'b0);
        do_exec(0, 1'b0, '0, 1'b0, 1'b0, VEC + 16'd1);
        do_check(1'b1, 1'b0, VEC + 16'd1, 1'b0, "R8 masked");
        // return, with jump also raised: return wins
        do_fetch(VEC + 16'd1, 2, 16'hF000, 1'b0);
        do_exec(1, 1'b1, 16'h0999, 1'b1, 1'b0, VEC + 16'd2);
        do_check(1'b0, 1'b0, 16'h0021, 1'b1, "R9 restore");
        // irq held during execute only
        do_fetch(16'h0021, 0, 16'h1234, 1'b0);
        do_exec(3, 1'b0, '0, 1'b0, 1'b1, 16'h0022);
        do_check(1'b0, 1'b0, 16'h0022, 1'b1, "R6 irq outside check");
        // reset in the middle of execute
        do_fetch(16'h0022, 0, 16'h4321, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset mid-exec pc", 32'(pc), 32'd0);
        check("R1 reset mid-exec req", {31'd0, mem_req}, 32'd1);
        check("R1 reset mid-exec valid", {31'd0, exec_valid}, 32'd0);
        check("R2 scoreboard drained", addr_q.size(), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule